// File: doc/BRIEF.md
# Countdown Watchdog Timer

This block is a countdown watchdog placed on a simple 16-bit register bus with byte enables. Software programs a tick count, clears a freeze bit to let the counter run, and restarts the countdown from time to time by writing to the reload word. A tick-enable pulse comes from a slow timebase elsewhere on the chip, and a prescale parameter sets how many of those pulses make one counter step.

When the counter runs out, the block sets a first-expiry status bit and starts the countdown again. If a second expiry happens while that status is still set, a second status bit is raised. The block also asserts a one-cycle system reset request, unless a separate reboot-guard flag is set. The freeze bit and the reboot-guard flag are two independent ways to keep the watchdog from resetting the system.

A generation parameter selects between two layouts. In the wide layout the initial count is a 10-bit field in its own word. In the narrow layout the initial count is a 6-bit field in the upper byte of the reload word. Reading the reload word returns the remaining count.

The control sequence has four states. ST_HALTED is the frozen state. ST_COUNTING is the running state. ST_EXPIRED is a one-cycle state that reloads the counter and updates status. ST_REBOOT is a one-cycle state that drives the reset request. The transitions are as follows:
- HALTED to COUNTING when the freeze bit is 0.
- COUNTING to HALTED when the freeze bit is 1.
- COUNTING to EXPIRED when a step is taken at a count of 0.
- EXPIRED to REBOOT when the first-expiry status was already set and the guard flag is 0.
- EXPIRED to COUNTING or HALTED otherwise, depending on the freeze bit.
- REBOOT to COUNTING or HALTED, depending on the freeze bit.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the following values hold:
  - the freeze bit (bit 11 of word 0x08) reads 1;
  - the reboot guard (bit 0 of word 0x0A) reads 1;
  - the initial count (word 0x12, bits 9:0) is INIT_DEFAULT = 50;
  - the remaining count reads 50;
  - both status words (0x04 and 0x06) read 0;
  - the reset request is 0.
- R2: While the freeze bit is 0, the count drops by exactly one after every TICK_DIV (default 2) tick pulses. While the freeze bit is 1, the count holds its value.
- R3: Any write to word 0x00 loads the count with the initial count and restarts the prescaler. This holds for any data value and any non-zero byte enable. Reading word 0x00 returns the count in bits 9:0 and zeros above.
- R4: A write to word 0x12 is handled as follows:
  - bits 15:10 are stored and read back as written;
  - bits 9:0 replace the initial count only when the written field is 4 or more;
  - a written field of 0 to 3 leaves the previous initial count in place.
- R5: Bit 11 of word 0x08 is a read/write freeze bit that reads back immediately after the write. The other bits of that word read 0.
- R6: A step taken while the count is 0 has three effects:
  - it sets the first-expiry status (bit 3 of word 0x04);
  - it reloads the count with the initial count;
  - counting then continues.
- R7: An expiry that occurs while bit 3 of word 0x04 is still set sets bit 1 of word 0x06. If the guard (bit 0 of word 0x0A) is 0, it also asserts reset_req for one cycle. If the guard is 1, it asserts no request.
- R8: Writing 1 to bit 3 of word 0x04 or to bit 1 of word 0x06 clears that status bit. Writing 0 to it leaves it unchanged.
- R9: A write changes only the byte lanes whose enables are set. Bus address bits 4:1 select the word. Reads of unmapped words return 0, and writes to unmapped words have no effect.
- R10: reset_req is never high for two cycles in a row. It is high only after a second status expiry with the guard clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase pulse, one cycle wide |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address within the 32-byte window |
| bus_be | input | 2 | Byte-lane enables (bit 0 is the low byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
A wrong control state shows up at the ports in one of two ways. Either the remaining count read from word 0x00 stops matching the tick arithmetic, or reset_req appears or is missing after the second expiry. A missed or extra prescaler step moves the count by one within TICK_DIV pulses. A stale status bit or a lost reboot guard changes the reset-request pulse count on the expiry that follows, within one countdown period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_HALTED,
        ST_COUNTING,
        ST_EXPIRED,
        ST_REBOOT
    } wdt_state_e;

    // Word indices (bus_addr[4:1])
    localparam logic [3:0] W_RELOAD = 4'h0;
    localparam logic [3:0] W_STS1   = 4'h2;
    localparam logic [3:0] W_STS2   = 4'h3;
    localparam logic [3:0] W_CTRL   = 4'h4;
    localparam logic [3:0] W_GUARD  = 4'h5;
    localparam logic [3:0] W_INIT   = 4'h9;

    localparam int FREEZE_BIT = 11;
    localparam int GUARD_BIT  = 0;
    localparam int EXP1_BIT   = 3;
    localparam int EXP2_BIT   = 1;
    localparam int MIN_COUNT  = 4;

    function automatic logic [15:0] lane_merge(input logic [15:0] old_v,
                                               input logic [15:0] new_v,
                                               input logic [1:0]  be);
        logic [15:0] r;
        r[7:0]  = be[0] ? new_v[7:0]  : old_v[7:0];
        r[15:8] = be[1] ? new_v[15:8] : old_v[15:8];
        return r;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int GEN          = 2,
    parameter int TW           = 10,
    parameter int INIT_DEFAULT = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [4:0]    bus_addr,
    input  logic [1:0]    bus_be,
    input  logic [15:0]   bus_wdata,
    input  logic [TW-1:0] count,
    input  logic          sts1,
    input  logic          sts2,
    output logic [15:0]   bus_rdata,
    output logic          halt,
    output logic          noreboot,
    output logic [TW-1:0] init_val,
    output logic          reload_pulse,
    output logic          clr1,
    output logic          clr2
);

    logic [3:0]  widx;
    logic [15:0] init_raw;
    logic [15:0] cand;
    logic        init_wr;
    logic        unused_addr0;

    assign widx         = bus_addr[4:1];
    assign unused_addr0 = bus_addr[0];
    assign init_val     = init_raw[TW-1:0];

    generate
        if (GEN == 1) begin : g_narrow
            assign init_wr      = bus_wr && (widx == W_RELOAD) && bus_be[1];
            assign reload_pulse = bus_wr && (widx == W_RELOAD) && bus_be[0];
            assign cand         = {8'h00, bus_wdata[15:8]};
        end else begin : g_wide
            assign init_wr      = bus_wr && (widx == W_INIT);
            assign reload_pulse = bus_wr && (widx == W_RELOAD) && (|bus_be);
            assign cand         = lane_merge(init_raw, bus_wdata, bus_be);
        end
    endgenerate

    assign clr1 = bus_wr && (widx == W_STS1) && bus_be[0] && bus_wdata[EXP1_BIT];
    assign clr2 = bus_wr && (widx == W_STS2) && bus_be[0] && bus_wdata[EXP2_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_raw <= 16'(INIT_DEFAULT);
            halt     <= 1'b1;
            noreboot <= 1'b1;
        end else begin
            if (init_wr) begin
                init_raw[15:TW] <= cand[15:TW];
                if (cand[TW-1:0] >= TW'(MIN_COUNT))
                    init_raw[TW-1:0] <= cand[TW-1:0];
            end
            if (bus_wr && (widx == W_CTRL) && bus_be[1])
                halt <= bus_wdata[FREEZE_BIT];
            if (bus_wr && (widx == W_GUARD) && bus_be[0])
                noreboot <= bus_wdata[GUARD_BIT];
        end
    end

    logic [15:0] rd_reload;
    logic [15:0] rd_init;

    generate
        if (GEN == 1) begin : g_rd_narrow
            assign rd_reload = {init_raw[7:0], 8'(count)};
            assign rd_init   = 16'h0000;
        end else begin : g_rd_wide
            assign rd_reload = 16'(count);
            assign rd_init   = init_raw;
        end
    endgenerate

    always_comb begin
        bus_rdata = 16'h0000;
        unique case (widx)
            W_RELOAD: bus_rdata = rd_reload;
            W_STS1:   bus_rdata[EXP1_BIT]   = sts1;
            W_STS2:   bus_rdata[EXP2_BIT]   = sts2;
            W_CTRL:   bus_rdata[FREEZE_BIT] = halt;
            W_GUARD:  bus_rdata[GUARD_BIT]  = noreboot;
            W_INIT:   bus_rdata = rd_init;
            default:  bus_rdata = 16'h0000;
        endcase
    end

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int TW           = 10,
    parameter int TICK_DIV     = 2,
    parameter int INIT_DEFAULT = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          halt,
    input  logic          noreboot,
    input  logic [TW-1:0] init_val,
    input  logic          reload_pulse,
    input  logic          clr1,
    input  logic          clr2,
    output logic [TW-1:0] count,
    output logic          sts1,
    output logic          sts2,
    output logic          reset_req
);

    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    wdt_state_e state_q, state_d;
    logic       running;
    logic       step;
    logic       wrap;
    logic [PW-1:0] presc_q;

    assign running = (state_q == ST_COUNTING) && !halt;

    generate
        if (TICK_DIV > 1) begin : g_div
            assign wrap = (presc_q == PW'(TICK_DIV - 1));
        end else begin : g_nodiv
            assign wrap = 1'b1;
        end
    endgenerate

    assign step = running && tick && wrap;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED:   if (!halt) state_d = ST_COUNTING;
            ST_COUNTING: begin
                if (halt)                           state_d = ST_HALTED;
                else if (step && (count == '0))     state_d = ST_EXPIRED;
            end
            ST_EXPIRED: begin
                if (sts1 && !noreboot) state_d = ST_REBOOT;
                else if (halt)         state_d = ST_HALTED;
                else                   state_d = ST_COUNTING;
            end
            ST_REBOOT:   state_d = halt ? ST_HALTED : ST_COUNTING;
            default:     state_d = ST_HALTED;
        endcase
    end

    // Outputs
    always_comb begin
        reset_req = (state_q == ST_REBOOT);
    end

    // Counter, prescaler and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= TW'(INIT_DEFAULT);
            presc_q <= '0;
            sts1    <= 1'b0;
            sts2    <= 1'b0;
        end else begin
            if (reload_pulse || (state_q == ST_EXPIRED)) begin
                count   <= init_val;
                presc_q <= '0;
            end else begin
                if (running && tick)
                    presc_q <= wrap ? '0 : presc_q + 1'b1;
                if (step && (count != '0))
                    count <= count - 1'b1;
            end

            if (state_q == ST_EXPIRED)
                sts1 <= 1'b1;
            else if (clr1)
                sts1 <= 1'b0;

            if ((state_q == ST_EXPIRED) && sts1)
                sts2 <= 1'b1;
            else if (clr2)
                sts2 <= 1'b0;
        end
    end

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
    parameter int GEN          = 2,
    parameter int TICK_DIV     = 2,
    parameter int INIT_DEFAULT = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        reset_req
);

    localparam int TW = (GEN == 1) ? 6 : 10;

    logic [TW-1:0] count;
    logic [TW-1:0] init_val;
    logic          sts1, sts2, halt, noreboot;
    logic          reload_pulse, clr1, clr2;

    wdt_regs #(.GEN(GEN), .TW(TW), .INIT_DEFAULT(INIT_DEFAULT)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .count(count),
        .sts1(sts1), .sts2(sts2), .bus_rdata(bus_rdata), .halt(halt),
        .noreboot(noreboot), .init_val(init_val),
        .reload_pulse(reload_pulse), .clr1(clr1), .clr2(clr2)
    );

    wdt_core #(.TW(TW), .TICK_DIV(TICK_DIV), .INIT_DEFAULT(INIT_DEFAULT)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt),
        .noreboot(noreboot), .init_val(init_val),
        .reload_pulse(reload_pulse), .clr1(clr1), .clr2(clr2),
        .count(count), .sts1(sts1), .sts2(sts2), .reset_req(reset_req)
    );

endmodule

// File: rtl/wdt_timer_sva.sv
module wdt_timer_sva #(
    parameter int TW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reset_req,
    input logic          halt,
    input logic          noreboot,
    input logic          sts1,
    input logic          sts2,
    input logic          reload_pulse,
    input logic [TW-1:0] count,
    input logic [TW-1:0] init_val
);

    // R10: request is a single-cycle pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R7: request only after a second expiry has been recorded
    a_r7_needs_second: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> sts2);

    // R7: guard flag blocks the request
    a_r7_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(!noreboot));

    // R2: frozen counter holds its value
    a_r2_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && $past(halt) && $past(halt, 2) && !$past(reload_pulse)) |-> $stable(count));

    // R2: count only ever decreases by one
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(reload_pulse) && (count < $past(count))) |-> (count == $past(count) - 1'b1));

    // R6: expiry reloads the count
    a_r6_expire_reload: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts1) |-> (count == $past(init_val)));

    // R4: programmed count never below the floor
    a_r4_init_floor: assert property (@(posedge clk) disable iff (!rst_n)
        init_val >= TW'(4));

endmodule

bind wdt_timer wdt_timer_sva #(.TW(TW)) u_sva (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .halt(halt),
    .noreboot(noreboot), .sts1(sts1), .sts2(sts2),
    .reload_pulse(reload_pulse), .count(count), .init_val(init_val)
);

// File: tb/wdt_timer_bench.sv
module wdt_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        reset_req;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int wide   = 0;
    bit done   = 0;
    logic prev_req = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    wdt_timer u_wdt_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .reset_req(reset_req)
    );

    always @(posedge clk) begin
        if (reset_req) pulses <= pulses + 1;
        if (reset_req && prev_req) wide <= wide + 1;
        prev_req <= reset_req;
    end

    // {write, byte addr, be, wdata, expected read at same addr}
    localparam int NV = 11;
    localparam logic [39:0] VEC [NV] = '{
        {1'b1, 5'h12, 2'b11, 16'h0002, 16'h0032},  // R4 low value ignored
        {1'b1, 5'h12, 2'b11, 16'hFC07, 16'hFC07},  // R4 upper bits kept
        {1'b1, 5'h12, 2'b01, 16'h0003, 16'hFC07},  // R9 R4 lane merge, field 3 ignored
        {1'b1, 5'h12, 2'b10, 16'h0100, 16'h0107},  // R9 upper lane only
        {1'b1, 5'h12, 2'b11, 16'h0004, 16'h0004},  // R4 minimum legal value
        {1'b1, 5'h0C, 2'b11, 16'hFFFF, 16'h0000},  // R9 unmapped write/read
        {1'b0, 5'h08, 2'b00, 16'h0000, 16'h0800},  // R5 freeze bit default
        {1'b1, 5'h08, 2'b01, 16'h0000, 16'h0800},  // R9 low lane misses bit 11
        {1'b1, 5'h0A, 2'b11, 16'h0000, 16'h0000},  // R7 guard cleared
        {1'b1, 5'h0A, 2'b11, 16'h0001, 16'h0001},  // R7 guard set again
        {1'b0, 5'h1E, 2'b00, 16'h0000, 16'h0000}   // R9 unmapped read
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 2'b00;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: bench hung actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 reset_req", int'(reset_req), 0);
        bus_read(5'h00, rd); check("R1 count", rd, 16'h0032);
        bus_read(5'h04, rd); check("R1 sts1", rd, 0);
        bus_read(5'h06, rd); check("R1 sts2", rd, 0);
        bus_read(5'h0A, rd); check("R1 guard", rd, 1);
        bus_read(5'h08, rd); check("R1 freeze", rd, 16'h0800);

        // Register vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][39]) bus_write(VEC[i][38:34], VEC[i][33:32], VEC[i][31:16]);
            bus_read(VEC[i][38:34], rd);
            check($sformatf("R4/R5/R9 vector %0d", i), rd, VEC[i][15:0]);
        end

        // R3 reload with arbitrary data loads initial count (4)
        bus_read(5'h00, rd); check("R2 frozen count untouched", rd, 16'h0032);
        bus_write(5'h00, 2'b01, 16'h005A);
        bus_read(5'h00, rd); check("R3 reload", rd, 4);
        ticks(4);
        bus_read(5'h00, rd); check("R2 halted holds", rd, 4);

        // R5 start, R2 count by TICK_DIV
        bus_write(5'h08, 2'b11, 16'h0000);
        bus_read(5'h08, rd); check("R5 freeze cleared", rd, 0);
        ticks(4);
        bus_read(5'h00, rd); check("R2 two steps", rd, 2);

        // R3 prescaler restart
        bus_write(5'h00, 2'b10, 16'h0000);
        bus_read(5'h00, rd); check("R3 reload running", rd, 4);
        ticks(1);
        bus_read(5'h00, rd); check("R3 prescaler restarted", rd, 4);
        ticks(1);
        bus_read(5'h00, rd); check("R2 step", rd, 3);

        // R6 first expiry
        ticks(8);
        bus_read(5'h00, rd); check("R6 reload on expiry", rd, 4);
        bus_read(5'h04, rd); check("R6 sts1 set", rd, 16'h0008);
        bus_read(5'h06, rd); check("R6 sts2 clear", rd, 0);

        // R7 second expiry with guard set: no request
        ticks(10);
        bus_read(5'h06, rd); check("R7 sts2 set", rd, 16'h0002);
        check("R7 guard blocks request", pulses, 0);

        // R8 write-one-to-clear
        bus_write(5'h04, 2'b11, 16'h0000);
        bus_read(5'h04, rd); check("R8 zero write keeps", rd, 16'h0008);
        bus_write(5'h04, 2'b11, 16'h0008);
        bus_read(5'h04, rd); check("R8 sts1 cleared", rd, 0);
        bus_write(5'h06, 2'b11, 16'h0002);
        bus_read(5'h06, rd); check("R8 sts2 cleared", rd, 0);

        // R7 guard clear: second expiry requests reset
        bus_write(5'h0A, 2'b11, 16'h0000);
        ticks(10);
        check("R7 first expiry no request", pulses, 0);
        ticks(10);
        check("R7 request pulse", pulses, 1);
        check("R10 pulse width one", wide, 0);
        bus_read(5'h06, rd); check("R7 sts2 after request", rd, 16'h0002);

        // R10 cleared first status: next expiry is a first one again
        bus_write(5'h04, 2'b01, 16'h0008);
        ticks(10);
        check("R10 no request after clear", pulses, 1);

        // R2 freeze holds count
        bus_write(5'h08, 2'b10, 16'h0800);
        bus_read(5'h08, rd); check("R5 freeze set", rd, 16'h0800);
        bus_read(5'h00, rd);
        begin
            logic [15:0] held;
            held = rd;
            ticks(6);
            bus_read(5'h00, rd); check("R2 freeze holds", rd, held);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule